// File: doc/BRIEF.md
# Two-Dimensional Error-Rate Margin Sweeper

This controller runs an on-chip bit-error-rate characterisation over a grid of offsets. It drives a timing-offset code and a voltage-offset code to the transmitter's offset controls. For each grid point it waits for the offsets to settle, then asks an external measurement engine for one error count taken over a programmed number of compared bits. It reduces that count to a logarithmic level code and emits the code, tagged with the grid address, on a result stream.

The timing axis is explored from the middle of the programmed range outward, one step to the right and then one to the left. At every timing position the complete voltage range is swept from its low end upward before the timing code moves again. Because each point is stored as a decade level instead of a raw count, a small memory of 4-bit entries is enough to paint a color-coded margin map.

Ranges and steps are sampled when a sweep is accepted and held for its whole duration. Both ranges assume low ≤ high. Back-pressure rules on the result stream: `res_valid` rises once per grid point. `res_addr` and `res_level` are held stable while `res_valid` is high and `res_ready` is low. The transfer takes place on the rising edge at which both are high. The sweep makes no progress while a result is waiting to be transferred.

Top module: `ber_sweep_ctrl`

## Requirements
- R1: A `start` pulse while idle raises `busy` on the next cycle. At that point `t_code` equals floor((t_lo + t_hi) / 2), `v_code` equals `v_lo`, and `meas_bits` presents the programmed bit window.
- R2: At each timing code the voltage codes are visited in the order v_lo, v_lo+s, v_lo+2s, and so on, up to the last value not above v_hi, before the timing code changes.
- R3: After the center, timing codes follow center+s, center−s, center+2s, center−2s, and so on. A side that has left [t_lo, t_hi] is skipped. The sweep ends when both sides are outside the range.
- R4: `meas_req` rises exactly `cfg_settle`+1 cycles after the offset codes take the values of a new grid point. The codes do not change while `meas_req` is high.
- R5: `meas_req` stays high until the cycle in which `meas_ack` is sampled high. The error count is taken from `meas_errs` in that cycle.
- R6: The level is the number of k in 1..15 for which errs·10^k < window. A zero error count with a nonzero window therefore gives 15, and errs·10 = window gives 0.
- R7: `res_addr` is {t_code, v_code} with the timing code in the upper TW bits. `res_valid`, `res_addr` and `res_level` hold steady until `res_ready` is high.
- R8: Exactly one result is transferred per grid point. `done` is high and `busy` is low in the cycle after the last transfer, and `done` is not raised before it.
- R9: A `start` pulse while `busy` is high is ignored. The running sweep continues with its sampled settings.
- R10: A step input of zero, on either axis, behaves as a step of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep when idle |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Last sweep finished; cleared by the next start |
| cfg_t_lo | input | TW | Lowest timing code |
| cfg_t_hi | input | TW | Highest timing code |
| cfg_t_step | input | TW | Timing step (0 acts as 1) |
| cfg_v_lo | input | VW | Lowest voltage code |
| cfg_v_hi | input | VW | Highest voltage code |
| cfg_v_step | input | VW | Voltage step (0 acts as 1) |
| cfg_settle | input | SW | Settle cycles after an offset change |
| cfg_window | input | CW | Compared bits per measurement |
| t_code | output | TW | Timing-offset code to the transmitter |
| v_code | output | VW | Voltage-offset code to the transmitter |
| meas_req | output | 1 | Measurement request |
| meas_ack | input | 1 | Measurement complete, count valid |
| meas_errs | input | CW | Error count of the measurement |
| meas_bits | output | CW | Bit window for the measurement engine |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result sink accepts |
| res_addr | output | TW+VW | Grid address {timing, voltage} |
| res_level | output | LW | Decade level of the error ratio |

## Verification
The bench builds the block with TW=5, VW=4, CW=16, LW=4 and SW=6. The 9-bit address space is small enough to keep a per-address write counter for every point, so a duplicated or missing point shows up. A 16-bit window of 1000 puts the exact decade boundary (errs = 100 against 99), zero-error saturation to 15 and error counts above the window within reach. Timing ranges of 2..9, 0..7 with step 3, 10..13 and a single point exercise even and odd centers, sides that run out at different times, and the zero-step rule.

// File: rtl/ber_sweep_pkg.sv
`timescale 1ns/1ps
package ber_sweep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_MEAS,
    ST_WRITE
  } sweep_state_e;

  // Power of ten as a 64-bit constant (valid for k <= 19).
  function automatic logic [63:0] pow10(input int unsigned k);
    logic [63:0] r;
    r = 64'd1;
    for (int unsigned i = 0; i < k; i++) r = r * 64'd10;
    return r;
  endfunction

endpackage

// File: rtl/sweep_settle_timer.sv
`timescale 1ns/1ps
module sweep_settle_timer #(
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] load_val,
  output logic          expired
);
  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - SW'(1);
  end

  assign expired = (cnt_q == '0);

  // R4: once loaded with a nonzero value the timer is not yet expired
  p_load_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load && (load_val != '0) |=> !expired);
endmodule

// File: rtl/sweep_center_order.sv
`timescale 1ns/1ps
module sweep_center_order #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          adv,
  input  logic [TW-1:0] lo_in,
  input  logic [TW-1:0] hi_in,
  input  logic [TW-1:0] step_in,
  output logic [TW-1:0] center,
  output logic          nxt_ok,
  output logic [TW-1:0] nxt_code
);
  localparam int PW = TW + 2;

  logic signed [PW-1:0] up_q, dn_q;
  logic [TW-1:0]        lo_q, hi_q, step_q;
  logic                 last_up_q;
  logic [TW:0]          mid_sum;
  logic [TW-1:0]        step_eff;
  logic                 up_in, dn_in, pick_up;

  assign mid_sum  = {1'b0, lo_in} + {1'b0, hi_in};
  assign center   = mid_sum[TW:1];
  assign step_eff = (step_in == '0) ? TW'(1) : step_in;

  assign up_in   = up_q <= $signed({2'b00, hi_q});
  assign dn_in   = dn_q >= $signed({2'b00, lo_q});
  assign pick_up = up_in && (!last_up_q || !dn_in);
  assign nxt_ok  = up_in || dn_in;
  assign nxt_code = pick_up ? up_q[TW-1:0] : dn_q[TW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q      <= '0;
      dn_q      <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      step_q    <= '0;
      last_up_q <= 1'b0;
    end else if (init) begin
      lo_q      <= lo_in;
      hi_q      <= hi_in;
      step_q    <= step_eff;
      up_q      <= $signed({2'b00, center}) + $signed({2'b00, step_eff});
      dn_q      <= $signed({2'b00, center}) - $signed({2'b00, step_eff});
      last_up_q <= 1'b0;
    end else if (adv && nxt_ok) begin
      if (pick_up) begin
        up_q      <= up_q + $signed({2'b00, step_q});
        last_up_q <= 1'b1;
      end else begin
        dn_q      <= dn_q - $signed({2'b00, step_q});
        last_up_q <= 1'b0;
      end
    end
  end

  // R3: every offered timing code lies inside the sampled range
  p_order_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_ok |-> (nxt_code >= lo_q) && (nxt_code <= hi_q));
endmodule

// File: rtl/ber_decade_quant.sv
`timescale 1ns/1ps
module ber_decade_quant #(
  parameter int CW = 16,
  parameter int LW = 4
) (
  input  logic [CW-1:0] errs,
  input  logic [CW-1:0] window,
  output logic [LW-1:0] level
);
  localparam int LMAX = (1 << LW) - 1;
  localparam int XW   = CW + 64;

  logic [LMAX-1:0] below;

  for (genvar k = 1; k <= LMAX; k++) begin : g_dec
    localparam logic [63:0] P10 = ber_sweep_pkg::pow10(k);
    logic [XW-1:0] scaled;
    assign scaled       = {64'd0, errs} * {{CW{1'b0}}, P10};
    assign below[k-1]   = scaled < {64'd0, window};
  end

  always_comb begin
    level = '0;
    for (int i = 0; i < LMAX; i++) level = level + LW'(below[i]);
  end
endmodule

// File: rtl/ber_sweep_ctrl.sv
`timescale 1ns/1ps
module ber_sweep_ctrl
  import ber_sweep_pkg::*;
#(
  parameter int TW = 5,
  parameter int VW = 4,
  parameter int CW = 16,
  parameter int LW = 4,
  parameter int SW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  input  logic [TW-1:0]    cfg_t_lo,
  input  logic [TW-1:0]    cfg_t_hi,
  input  logic [TW-1:0]    cfg_t_step,
  input  logic [VW-1:0]    cfg_v_lo,
  input  logic [VW-1:0]    cfg_v_hi,
  input  logic [VW-1:0]    cfg_v_step,
  input  logic [SW-1:0]    cfg_settle,
  input  logic [CW-1:0]    cfg_window,
  output logic [TW-1:0]    t_code,
  output logic [VW-1:0]    v_code,
  output logic             meas_req,
  input  logic             meas_ack,
  input  logic [CW-1:0]    meas_errs,
  output logic [CW-1:0]    meas_bits,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [TW+VW-1:0] res_addr,
  output logic [LW-1:0]    res_level
);
  localparam int AW   = TW + VW;
  localparam int LMAX = (1 << LW) - 1;

  sweep_state_e  state_q;
  logic [VW-1:0] v_lo_q, v_hi_q, v_step_q;
  logic [SW-1:0] settle_q;
  logic [CW-1:0] win_q;

  logic          accept, xfer, v_more, next_pt;
  logic [VW:0]   v_sum;
  logic          tmr_load, tmr_exp;
  logic [SW-1:0] tmr_val;
  logic [TW-1:0] ord_center, ord_code;
  logic          ord_ok, ord_adv;
  logic [LW-1:0] q_level;

  assign accept  = (state_q == ST_IDLE) && start;
  assign xfer    = (state_q == ST_WRITE) && res_ready;
  assign v_sum   = {1'b0, v_code} + {1'b0, v_step_q};
  assign v_more  = v_sum <= {1'b0, v_hi_q};
  assign next_pt = xfer && (v_more || ord_ok);
  assign ord_adv = xfer && !v_more;
  assign tmr_load = accept || next_pt;
  assign tmr_val  = accept ? cfg_settle : settle_q;
  assign meas_bits = win_q;

  sweep_settle_timer #(.SW(SW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_exp)
  );

  sweep_center_order #(.TW(TW)) u_order (
    .clk(clk), .rst_n(rst_n), .init(accept), .adv(ord_adv),
    .lo_in(cfg_t_lo), .hi_in(cfg_t_hi), .step_in(cfg_t_step),
    .center(ord_center), .nxt_ok(ord_ok), .nxt_code(ord_code)
  );

  ber_decade_quant #(.CW(CW), .LW(LW)) u_quant (
    .errs(meas_errs), .window(win_q), .level(q_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      t_code    <= '0;
      v_code    <= '0;
      v_lo_q    <= '0;
      v_hi_q    <= '0;
      v_step_q  <= '0;
      settle_q  <= '0;
      win_q     <= '0;
      meas_req  <= 1'b0;
      res_valid <= 1'b0;
      res_addr  <= '0;
      res_level <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          v_lo_q   <= cfg_v_lo;
          v_hi_q   <= cfg_v_hi;
          v_step_q <= (cfg_v_step == '0) ? VW'(1) : cfg_v_step;
          settle_q <= cfg_settle;
          win_q    <= cfg_window;
          t_code   <= ord_center;
          v_code   <= cfg_v_lo;
          busy     <= 1'b1;
          done     <= 1'b0;
          state_q  <= ST_SETTLE;
        end
        ST_SETTLE: if (tmr_exp) begin
          meas_req <= 1'b1;
          state_q  <= ST_MEAS;
        end
        ST_MEAS: if (meas_ack) begin
          meas_req  <= 1'b0;
          res_valid <= 1'b1;
          res_addr  <= AW'({t_code, v_code});
          res_level <= q_level;
          state_q   <= ST_WRITE;
        end
        ST_WRITE: if (res_ready) begin
          res_valid <= 1'b0;
          if (v_more) begin
            v_code  <= v_sum[VW-1:0];
            state_q <= ST_SETTLE;
          end else if (ord_ok) begin
            t_code  <= ord_code;
            v_code  <= v_lo_q;
            state_q <= ST_SETTLE;
          end else begin
            busy    <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5: a pending request is held until acknowledged
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req && !meas_ack |=> meas_req);

  // R4: offset codes are frozen while a measurement is requested
  p_codes_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req |-> $stable(t_code) && $stable(v_code));

  // R7: result stream holds its payload under back-pressure
  p_res_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr) && $stable(res_level));

  // R5: request and pending result never overlap
  p_req_res_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_req && res_valid));

  // R9: a start while busy does not end or restart the sweep
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !res_valid |=> busy);

  // R8: completion follows a result transfer
  p_done_after_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(res_valid && res_ready) && !busy);

  // R6: zero errors over a nonzero window saturate the level
  p_zero_err_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MEAS) && meas_ack && (meas_errs == '0) && (win_q != '0)
    |=> res_level == LW'(LMAX));
endmodule

// File: tb/ber_sweep_ctrl_tb_top.sv
`timescale 1ns/1ps
module ber_sweep_ctrl_tb_top;
  localparam int TW = 5, VW = 4, CW = 16, LW = 4, SW = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, meas_req, res_valid;
  logic [TW-1:0] cfg_t_lo = '0, cfg_t_hi = '0, cfg_t_step = '0, t_code;
  logic [VW-1:0] cfg_v_lo = '0, cfg_v_hi = '0, cfg_v_step = '0, v_code;
  logic [SW-1:0] cfg_settle = '0;
  logic [CW-1:0] cfg_window = '0, meas_errs = '0, meas_bits;
  logic meas_ack = 1'b0, res_ready = 1'b0;
  logic [TW+VW-1:0] res_addr;
  logic [LW-1:0] res_level;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int et[0:255], ev[0:255];
  int n_exp;
  int wcnt[0:511];

  always #2.5 clk = ~clk;

  ber_sweep_ctrl #(.TW(TW), .VW(VW), .CW(CW), .LW(LW), .SW(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .cfg_t_lo(cfg_t_lo), .cfg_t_hi(cfg_t_hi), .cfg_t_step(cfg_t_step),
    .cfg_v_lo(cfg_v_lo), .cfg_v_hi(cfg_v_hi), .cfg_v_step(cfg_v_step),
    .cfg_settle(cfg_settle), .cfg_window(cfg_window),
    .t_code(t_code), .v_code(v_code), .meas_req(meas_req),
    .meas_ack(meas_ack), .meas_errs(meas_errs), .meas_bits(meas_bits),
    .res_valid(res_valid), .res_ready(res_ready), .res_addr(res_addr),
    .res_level(res_level)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Error count presented by the stand-in measurement engine.
  function automatic logic [CW-1:0] errfn(input int t, input int v);
    case ((t * 3 + v) % 8)
      0: return 16'd0;
      1: return 16'd1;
      2: return 16'd9;
      3: return 16'd99;
      4: return 16'd100;
      5: return 16'd1000;
      6: return 16'd4;
      default: return 16'd65535;
    endcase
  endfunction

  // R6 expectation: count k in 1..15 with errs*10^k < window.
  function automatic int exp_lvl(input longint e, input longint w);
    int l = 0;
    longint p = e * 10;
    while (l < 15 && p < w) begin
      l++;
      p = p * 10;
    end
    return l;
  endfunction

  task automatic add_col(input int t, input int vlo, input int vhi, input int vs);
    for (int v = vlo; v <= vhi; v += vs) begin
      et[n_exp] = t;
      ev[n_exp] = v;
      n_exp++;
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(busy == 0, "reset busy", busy, 0);
    chk(done == 0, "reset done", done, 0);
    chk(meas_req == 0, "reset meas_req", meas_req, 0);
    chk(res_valid == 0, "reset res_valid", res_valid, 0);
  endtask

  task automatic run_sweep(input int tlo, input int thi, input int ts,
                           input int vlo, input int vhi, input int vs,
                           input int settle, input int win, input bit bp, input bit inj);
    int idx = 0, cyc = 0, seen = 0, since = 0, c, sst, vss;
    int pt, pv;
    bit prq = 0, last = 0, early = 0, injd = 0, hold = 0;
    logic [TW+VW-1:0] haddr = '0;
    // expected visiting order from R2, R3, R10
    sst = (ts == 0) ? 1 : ts;
    vss = (vs == 0) ? 1 : vs;
    c = (tlo + thi) / 2;
    n_exp = 0;
    add_col(c, vlo, vhi, vss);
    for (int k = 1; k < 64; k++) begin
      if (c + k * sst > thi && c - k * sst < tlo) break;
      if (c + k * sst <= thi) add_col(c + k * sst, vlo, vhi, vss);
      if (c - k * sst >= tlo) add_col(c - k * sst, vlo, vhi, vss);
    end
    for (int a = 0; a < 512; a++) wcnt[a] = 0;

    @(negedge clk);
    cfg_t_lo = TW'(tlo); cfg_t_hi = TW'(thi); cfg_t_step = TW'(ts);
    cfg_v_lo = VW'(vlo); cfg_v_hi = VW'(vhi); cfg_v_step = VW'(vs);
    cfg_settle = SW'(settle); cfg_window = CW'(win);
    res_ready = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1, "R1 busy after start", busy, 1);
    chk(t_code == TW'(c), "R1 first timing code is center", t_code, c);
    chk(v_code == VW'(vlo), "R1 first voltage code", v_code, vlo);
    chk(meas_bits == CW'(win), "R1 window presented", meas_bits, win);
    pt = t_code; pv = v_code;

    while (!last && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (start) begin
        start = 1'b0;
        chk(busy == 1, "R9 start while busy ignored", busy, 1);
      end
      if (hold) begin
        chk(res_valid == 1 && res_addr == haddr, "R7 payload held under back-pressure",
            res_addr, haddr);
      end
      if (int'(t_code) != pt || int'(v_code) != pv) since = 0;
      else since++;
      pt = t_code; pv = v_code;
      if (meas_req && !prq) chk(since == settle + 1, "R4 settle delay", since, settle + 1);
      prq = meas_req;
      if (meas_ack) begin
        meas_ack = 1'b0;
        seen = 0;
      end else if (meas_req) begin
        seen++;
        if (seen >= 2) begin
          meas_ack  = 1'b1;
          meas_errs = errfn(t_code, v_code);
        end
      end
      if (done) early = 1;
      res_ready = bp ? ((cyc % 3) != 0) : 1'b1;
      hold  = res_valid && !res_ready;
      haddr = res_addr;
      if (res_valid && res_ready) begin
        if (idx < n_exp) begin
          chk(res_addr[TW+VW-1:VW] == TW'(et[idx]), "R3 timing order",
              res_addr[TW+VW-1:VW], et[idx]);
          chk(res_addr[VW-1:0] == VW'(ev[idx]), "R2 voltage order",
              res_addr[VW-1:0], ev[idx]);
          chk(int'(res_level) == exp_lvl(errfn(et[idx], ev[idx]), win), "R6 level",
              res_level, exp_lvl(errfn(et[idx], ev[idx]), win));
        end
        chk(wcnt[res_addr] == 0, "R8 one write per point", wcnt[res_addr], 0);
        wcnt[res_addr]++;
        idx++;
        if (idx >= n_exp) last = 1;
      end
      if (inj && idx == 3 && !injd) begin
        injd = 1;
        start = 1'b1;
        cfg_t_lo = '0; cfg_t_hi = '1; cfg_v_lo = '0;
      end
    end
    @(negedge clk);
    res_ready = 1'b0;
    chk(cyc < 20000, "R8 sweep completes", cyc, 20000);
    chk(idx == n_exp, "R8 point count", idx, n_exp);
    chk(done == 1, "R8 done one cycle after last write", done, 1);
    chk(busy == 0, "R8 busy low at end", busy, 0);
    chk(!early, "R8 no early done", early, 0);
  endtask

  initial begin
    #1000000;
    chk(0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_reset();
    // even range, back-pressure, start injected while busy (R9)
    run_sweep(2, 9, 1, 0, 3, 1, 2, 1000, 1'b1, 1'b1);
    // coarse step, sides run out together, no settle
    run_sweep(0, 7, 3, 1, 6, 2, 0, 1000, 1'b0, 1'b0);
    // lower side ends first, single voltage
    run_sweep(10, 13, 1, 5, 5, 1, 1, 1000, 1'b1, 1'b0);
    // zero steps act as one (R10), wide window
    run_sweep(4, 4, 0, 2, 4, 0, 5, 50000, 1'b0, 1'b0);
    finish_up();
  end
endmodule